// File: doc/BRIEF.md
# Triggered Multi-Channel ADC Scan Sequencer

This block drives a serial analog-to-digital converter through a complete scan each time a trigger pulse arrives. A 16-bit enable mask chooses which inputs take part. Mask bits 0 to 7 select the eight single-ended inputs. Mask bits 8 to 15 select the eight differential pairs (0 against 1, 1 against 0, 2 against 3, and so on up to 7 against 6). For every enabled index, in ascending order, the block sends a conversion command over a mode-0 SPI link. It then waits for a rising edge on the converter's end-of-conversion line before it sends the next command.

The converter answers each transfer with the result of the conversion commanded one transfer earlier. The sequencer therefore throws away whatever arrives with the first command of a scan. It files each later reply under the index that was commanded before, and it ends every scan with a read-status command that fetches the final result. All results are held until the scan has finished cleanly. They are then streamed out one per cycle, each tagged with its own index, and a scan-done pulse follows.

If the end-of-conversion edge does not arrive within the configured timeout, the scan is abandoned. The block raises a one-cycle error and releases none of that scan's samples.

Top module: `adc_scan_seq`

## Requirements
- R1: Each scan sends one command per enabled index in ascending index order, then one status command 0x0C. The first byte of a conversion command is laid out as follows:
  - bit 7 is 1 for indices 0–7 and 0 for indices 8–15;
  - bits 6:4 hold the mux code of input k = index mod 8, where inputs 0..7 map to codes 0,4,1,5,2,6,3,7;
  - bits 3:0 are zero.

  The second byte of every command is 0x00.
- R2: Every transfer is 16 SCLK periods long, MSB first, SPI mode 0 (SCLK idles low, data sampled on the rising edge), with chip select held low for the whole transfer.
- R3: The word returned during the first command of a scan is discarded. The word returned during transfer k+1 is the result for the index commanded in transfer k.
- R4: A sample value is bits 15:3 of the returned word, treated as a 13-bit two's-complement number and sign-extended to 16 bits. Bits 2:0 of the word have no effect.
- R5: After each conversion command, the next transfer starts only after a rising edge of the end-of-conversion input.
- R6: If no end-of-conversion rising edge arrives within TIMEOUT_CYC clock cycles after a conversion command, the block does all of the following:
  - pulses the timeout error for one cycle;
  - returns to idle with busy low;
  - sends no further transfers;
  - emits no sample and no scan-done for that scan.
- R7: After the status transfer, each enabled index is emitted exactly once, in ascending order, with the valid strobe, the index and the value. Scan-done then pulses once. Valid, done and error never coincide.
- R8: A trigger with an all-zero mask causes no transfer and no busy. Scan-done pulses in the cycle after the trigger.
- R9: Busy is high from the cycle after an accepted trigger until the scan ends. A trigger that arrives while busy is ignored: the mask and the running scan are unchanged.
- R10: After reset, chip select is high, SCLK is low, and busy, valid, done and error are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Scan start pulse |
| mask_i | input | 16 | Enable mask sampled with the trigger |
| busy_o | output | 1 | Scan in progress |
| spi_sclk_o | output | 1 | Serial clock to the converter |
| spi_cs_n_o | output | 1 | Active-low chip select |
| spi_mosi_o | output | 1 | Command data to the converter |
| spi_miso_i | input | 1 | Result data from the converter |
| eoc_i | input | 1 | End-of-conversion (asynchronous, rising edge used) |
| smp_valid_o | output | 1 | Sample strobe |
| smp_idx_o | output | 4 | Index the sample belongs to |
| smp_val_o | output | OUT_W | Sign-extended sample value |
| scan_done_o | output | 1 | One-cycle pulse after a completed scan |
| timeout_err_o | output | 1 | One-cycle pulse on an aborted scan |

## Verification
Random masks are used to expose ordering and attribution faults. Dense masks pair every reply with the command just before it, and sparse masks show whether skipped indices shift the one-transfer lag. Directed scans cover the rest:
- full-scale positive, full-scale negative and minus-one words with non-zero low bits, which separate a correct shift and sign extension from a plain truncation;
- an empty mask;
- a second trigger arriving mid-scan;
- a missing end-of-conversion edge on the first, a middle and the last command, which shows that the abort suppresses every sample regardless of how far the scan had progressed.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

    localparam int NUM_IDX = 16;
    localparam int IDX_W   = $clog2(NUM_IDX);
    localparam int XFER_W  = 16;
    localparam int CMD_W   = 8;
    localparam int RES_W   = 13;
    localparam int HALF    = NUM_IDX / 2;

    localparam logic [CMD_W-1:0] STATUS_CMD = 8'h0C;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SEND   = 3'd1,
        ST_XFER   = 3'd2,
        ST_WAIT   = 3'd3,
        ST_FLUSH  = 3'd4,
        ST_FLUSHX = 3'd5,
        ST_DRAIN  = 3'd6,
        ST_DONE   = 3'd7
    } scan_state_e;

endpackage

// File: rtl/scan_cmd_enc.sv
module scan_cmd_enc
    import adc_scan_pkg::*;
(
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              status_i,
    output logic [XFER_W-1:0] word_o
);

    localparam int CH_W = $clog2(HALF);

    logic [CH_W-1:0]  ch;
    logic [CH_W-1:0]  mux_code;
    logic [CMD_W-1:0] cmd;

    assign ch = idx_i[CH_W-1:0];

    // mux code is the input number rotated right by one bit
    generate
        for (genvar b = 0; b < CH_W; b++) begin : g_rot
            if (b == CH_W - 1) begin : g_top
                assign mux_code[b] = ch[0];
            end else begin : g_low
                assign mux_code[b] = ch[b+1];
            end
        end
    endgenerate

    always_comb begin
        if (status_i) begin
            cmd = STATUS_CMD;
        end else begin
            cmd = '0;
            cmd[CMD_W-1] = ~idx_i[IDX_W-1];
            cmd[CMD_W-2 -: CH_W] = mux_code;
        end
    end

    assign word_o = {cmd, {(XFER_W-CMD_W){1'b0}}};

endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
    import adc_scan_pkg::*;
#(
    parameter int CLK_DIV = 4,
    parameter int KEEP_W  = RES_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [XFER_W-1:0] tx_i,
    output logic              done_o,
    output logic [KEEP_W-1:0] rx_o,
    output logic              sclk_o,
    output logic              cs_n_o,
    output logic              mosi_o,
    input  logic              miso_i
);

    localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam int BIT_W = $clog2(XFER_W);

    typedef struct packed {
        logic              active;
        logic              cs_n;
        logic              sclk;
        logic              done;
        logic [DIV_W-1:0]  div;
        logic [BIT_W-1:0]  bitcnt;
        logic [XFER_W-1:0] tx;
        logic [XFER_W-1:0] rx;
    } eng_t;

    eng_t e_d, e_q;

    always_comb begin
        e_d = e_q;
        e_d.done = 1'b0;
        if (!e_q.active) begin
            if (start_i) begin
                e_d.active = 1'b1;
                e_d.cs_n   = 1'b0;
                e_d.sclk   = 1'b0;
                e_d.div    = '0;
                e_d.bitcnt = '0;
                e_d.tx     = tx_i;
                e_d.rx     = '0;
            end
        end else if (e_q.div == DIV_W'(CLK_DIV - 1)) begin
            e_d.div = '0;
            if (!e_q.sclk) begin
                e_d.sclk = 1'b1;
                e_d.rx   = {e_q.rx[XFER_W-2:0], miso_i};
            end else begin
                e_d.sclk = 1'b0;
                e_d.tx   = {e_q.tx[XFER_W-2:0], 1'b0};
                if (e_q.bitcnt == BIT_W'(XFER_W - 1)) begin
                    e_d.active = 1'b0;
                    e_d.cs_n   = 1'b1;
                    e_d.done   = 1'b1;
                end else begin
                    e_d.bitcnt = e_q.bitcnt + 1'b1;
                end
            end
        end else begin
            e_d.div = e_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q      <= '0;
            e_q.cs_n <= 1'b1;
        end else begin
            e_q <= e_d;
        end
    end

    assign done_o = e_q.done;
    assign rx_o   = e_q.rx[XFER_W-1 -: KEEP_W];
    assign sclk_o = e_q.sclk;
    assign cs_n_o = e_q.cs_n;
    assign mosi_o = e_q.tx[XFER_W-1];

    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sclk_o); // R2
    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> cs_n_o); // R2
    AST_CS_LOW_TO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_o && !done_o) |=> (!cs_n_o || done_o)); // R2

endmodule

// File: rtl/eoc_watch.sv
module eoc_watch #(
    parameter int TIMEOUT_CYC = 10_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic eoc_i,
    output logic seen_o,
    output logic tmo_o
);

    localparam int CNT_W = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;

    typedef struct packed {
        logic [1:0]       sync;
        logic             last;
        logic             armed;
        logic [CNT_W-1:0] cnt;
        logic             seen;
        logic             tmo;
    } watch_t;

    watch_t w_d, w_q;
    logic   rise;

    assign rise = w_q.sync[1] & ~w_q.last;

    always_comb begin
        w_d = w_q;
        w_d.sync = {w_q.sync[0], eoc_i};
        w_d.last = w_q.sync[1];
        w_d.seen = 1'b0;
        w_d.tmo  = 1'b0;
        if (arm_i) begin
            w_d.armed = 1'b1;
            w_d.cnt   = '0;
        end else if (w_q.armed) begin
            if (rise) begin
                w_d.seen  = 1'b1;
                w_d.armed = 1'b0;
            end else if (w_q.cnt == CNT_W'(TIMEOUT_CYC - 1)) begin
                w_d.tmo   = 1'b1;
                w_d.armed = 1'b0;
            end else begin
                w_d.cnt = w_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q <= '0;
        end else begin
            w_q <= w_d;
        end
    end

    assign seen_o = w_q.seen;
    assign tmo_o  = w_q.tmo;

    AST_NO_EARLY_TMO: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i |=> !tmo_o); // R6
    AST_SEEN_TMO_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(seen_o && tmo_o)); // R6

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_scan_pkg::*;
#(
    parameter int CLK_DIV     = 4,
    parameter int TIMEOUT_CYC = 10_000_000,
    parameter int OUT_W       = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 trig_i,
    input  logic [NUM_IDX-1:0]   mask_i,
    output logic                 busy_o,
    output logic                 spi_sclk_o,
    output logic                 spi_cs_n_o,
    output logic                 spi_mosi_o,
    input  logic                 spi_miso_i,
    input  logic                 eoc_i,
    output logic                 smp_valid_o,
    output logic [IDX_W-1:0]     smp_idx_o,
    output logic [OUT_W-1:0]     smp_val_o,
    output logic                 scan_done_o,
    output logic                 timeout_err_o
);

    typedef struct packed {
        scan_state_e                 state;
        logic [NUM_IDX-1:0]          mask;
        logic [IDX_W-1:0]            cur;
        logic [IDX_W-1:0]            prev;
        logic [IDX_W-1:0]            ptr;
        logic                        have_prev;
        logic [NUM_IDX-1:0][RES_W-1:0] res;
        logic                        smp_valid;
        logic [IDX_W-1:0]            smp_idx;
        logic [OUT_W-1:0]            smp_val;
        logic                        done;
        logic                        err;
    } regs_t;

    regs_t r_d, r_q;

    logic              spi_start;
    logic              flush_sel;
    logic              eoc_arm;
    logic              spi_done;
    logic [RES_W-1:0]  spi_rx;
    logic [XFER_W-1:0] tx_word;
    logic              eoc_seen;
    logic              eoc_tmo;
    logic [IDX_W:0]    nxt;

    function automatic logic [IDX_W:0] first_from(input logic [NUM_IDX-1:0] m,
                                                  input logic [IDX_W:0]     from);
        logic [IDX_W:0] hit;
        hit = (IDX_W+1)'(NUM_IDX);
        for (int i = NUM_IDX - 1; i >= 0; i--) begin
            if (m[i] && ((IDX_W+1)'(i) >= from)) begin
                hit = (IDX_W+1)'(i);
            end
        end
        return hit;
    endfunction

    function automatic logic [OUT_W-1:0] sext(input logic [RES_W-1:0] v);
        return {{(OUT_W-RES_W){v[RES_W-1]}}, v};
    endfunction

    scan_cmd_enc u_enc (
        .idx_i    (r_q.cur),
        .status_i (flush_sel),
        .word_o   (tx_word)
    );

    spi_xfer_engine #(
        .CLK_DIV (CLK_DIV),
        .KEEP_W  (RES_W)
    ) u_spi (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (spi_start),
        .tx_i    (tx_word),
        .done_o  (spi_done),
        .rx_o    (spi_rx),
        .sclk_o  (spi_sclk_o),
        .cs_n_o  (spi_cs_n_o),
        .mosi_o  (spi_mosi_o),
        .miso_i  (spi_miso_i)
    );

    eoc_watch #(
        .TIMEOUT_CYC (TIMEOUT_CYC)
    ) u_eoc (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm_i  (eoc_arm),
        .eoc_i  (eoc_i),
        .seen_o (eoc_seen),
        .tmo_o  (eoc_tmo)
    );

    always_comb begin
        r_d = r_q;
        r_d.smp_valid = 1'b0;
        r_d.done      = 1'b0;
        r_d.err       = 1'b0;
        spi_start     = 1'b0;
        flush_sel     = 1'b0;
        eoc_arm       = 1'b0;
        nxt           = '0;
        case (r_q.state)
            ST_IDLE: begin
                if (trig_i) begin
                    if (mask_i == '0) begin
                        r_d.done = 1'b1;
                    end else begin
                        nxt           = first_from(mask_i, '0);
                        r_d.mask      = mask_i;
                        r_d.cur       = nxt[IDX_W-1:0];
                        r_d.have_prev = 1'b0;
                        r_d.state     = ST_SEND;
                    end
                end
            end
            ST_SEND: begin
                spi_start = 1'b1;
                r_d.state = ST_XFER;
            end
            ST_XFER: begin
                if (spi_done) begin
                    if (r_q.have_prev) begin
                        r_d.res[r_q.prev] = spi_rx;
                    end
                    r_d.prev      = r_q.cur;
                    r_d.have_prev = 1'b1;
                    eoc_arm       = 1'b1;
                    r_d.state     = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (eoc_tmo) begin
                    r_d.err   = 1'b1;
                    r_d.state = ST_IDLE;
                end else if (eoc_seen) begin
                    nxt = first_from(r_q.mask, {1'b0, r_q.cur} + 1'b1);
                    if (nxt[IDX_W]) begin
                        r_d.state = ST_FLUSH;
                    end else begin
                        r_d.cur   = nxt[IDX_W-1:0];
                        r_d.state = ST_SEND;
                    end
                end
            end
            ST_FLUSH: begin
                spi_start = 1'b1;
                flush_sel = 1'b1;
                r_d.state = ST_FLUSHX;
            end
            ST_FLUSHX: begin
                if (spi_done) begin
                    r_d.res[r_q.prev] = spi_rx;
                    r_d.ptr           = '0;
                    r_d.state         = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                r_d.smp_valid = r_q.mask[r_q.ptr];
                r_d.smp_idx   = r_q.ptr;
                r_d.smp_val   = sext(r_q.res[r_q.ptr]);
                if (r_q.ptr == IDX_W'(NUM_IDX - 1)) begin
                    r_d.state = ST_DONE;
                end else begin
                    r_d.ptr = r_q.ptr + 1'b1;
                end
            end
            ST_DONE: begin
                r_d.done  = 1'b1;
                r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o        = (r_q.state != ST_IDLE);
    assign smp_valid_o   = r_q.smp_valid;
    assign smp_idx_o     = r_q.smp_idx;
    assign smp_val_o     = r_q.smp_val;
    assign scan_done_o   = r_q.done;
    assign timeout_err_o = r_q.err;

    AST_IDLE_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> spi_cs_n_o); // R10
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({smp_valid_o, scan_done_o, timeout_err_o})); // R7
    AST_SAMPLE_IN_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid_o |-> busy_o); // R7
    AST_SAMPLE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid_o |-> r_q.mask[smp_idx_o]); // R7
    AST_ERR_ENDS_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err_o |-> !busy_o); // R6
    AST_EMPTY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_i && !busy_o && (mask_i == '0)) |=> (scan_done_o && !busy_o)); // R8
    AST_TRIG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_i && busy_o) |=> $stable(r_q.mask)); // R9

endmodule

// File: tb/adc_scan_seq_test.sv
`timescale 1ns/1ps
module adc_scan_seq_test;

    localparam int TMO = 400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig = 1'b0;
    logic [15:0] mask = '0;
    logic        busy, sclk, cs_n, mosi, miso, eoc;
    logic        smp_valid, done, err;
    logic [3:0]  smp_idx;
    logic [15:0] smp_val;

    always #5 clk = ~clk;

    adc_scan_seq #(.CLK_DIV(2), .TIMEOUT_CYC(TMO), .OUT_W(16)) uut (
        .clk(clk), .rst_n(rst_n), .trig_i(trig), .mask_i(mask), .busy_o(busy),
        .spi_sclk_o(sclk), .spi_cs_n_o(cs_n), .spi_mosi_o(mosi), .spi_miso_i(miso),
        .eoc_i(eoc), .smp_valid_o(smp_valid), .smp_idx_o(smp_idx), .smp_val_o(smp_val),
        .scan_done_o(done), .timeout_err_o(err)
    );

    int n_chk = 0;
    int n_fail = 0;

    // converter model state
    logic [15:0] word_tbl [0:255];
    logic [15:0] prev_word = '0;
    logic [15:0] shout = '0;
    logic [7:0]  cmd_in = '0;
    int          bits = 0;
    logic        cs_l = 1'b1, sclk_l = 1'b0, cs_prev = 1'b1;
    logic        eoc_pend = 1'b0;
    int          eoc_wait = 0, eoc_hold = 0;
    int          eoc_viol = 0, bad_len = 0;
    int          conv_n = 0, cmd_n = 0;
    int          sup_abs = -1;
    logic [7:0]  cmd_log [0:2047];

    // sample monitor
    int          s_n = 0, done_n = 0, err_n = 0;
    logic [3:0]  s_idx [0:2047];
    logic [15:0] s_val [0:2047];

    initial eoc = 1'b0;
    initial miso = 1'b0;

    always @(spi_cs_n_change or sclk) begin end

    wire spi_cs_n_change = cs_n;

    always @(cs_n or sclk) begin
        if (cs_l === 1'b1 && cs_n === 1'b0) begin
            if (eoc_pend) eoc_viol++;
            shout  = prev_word;
            miso   = shout[15];
            bits   = 0;
            cmd_in = '0;
        end else if (cs_n === 1'b0 && sclk_l === 1'b0 && sclk === 1'b1) begin
            if (bits < 8) cmd_in = {cmd_in[6:0], mosi};
            bits++;
        end else if (cs_n === 1'b0 && sclk_l === 1'b1 && sclk === 1'b0) begin
            shout = {shout[14:0], 1'b0};
            miso  = shout[15];
        end
        cs_l   = cs_n;
        sclk_l = sclk;
    end

    always @(negedge clk) begin
        if (cs_prev === 1'b0 && cs_n === 1'b1) begin
            if (bits != 16) bad_len++;
            if (cmd_n < 2048) cmd_log[cmd_n] = cmd_in;
            cmd_n++;
            if (cmd_in != 8'h0C) begin
                conv_n++;
                prev_word = word_tbl[cmd_in];
                if (conv_n != sup_abs) begin
                    eoc_wait = 5 + int'($urandom % 36);
                    eoc_pend = 1'b1;
                end
            end
        end
        cs_prev = cs_n;
        if (eoc_wait > 0) begin
            eoc_wait--;
            if (eoc_wait == 0) begin
                eoc = 1'b1;
                eoc_hold = 3;
                eoc_pend = 1'b0;
            end
        end else if (eoc_hold > 0) begin
            eoc_hold--;
            if (eoc_hold == 0) eoc = 1'b0;
        end
        if (smp_valid === 1'b1) begin
            if (s_n < 2048) begin
                s_idx[s_n] = smp_idx;
                s_val[s_n] = smp_val;
            end
            s_n++;
        end
        if (done === 1'b1) done_n++;
        if (err === 1'b1) err_n++;
    end

    function automatic logic [7:0] exp_cmd(input int i);
        logic [2:0] m;
        case (i % 8)
            0: m = 3'd0; 1: m = 3'd4; 2: m = 3'd1; 3: m = 3'd5;
            4: m = 3'd2; 5: m = 3'd6; 6: m = 3'd3; default: m = 3'd7;
        endcase
        return {(i < 8) ? 1'b1 : 1'b0, m, 4'b0000};
    endfunction

    function automatic logic [15:0] exp_val(input logic [15:0] w);
        return {{3{w[15]}}, w[15:3]};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic fill_tbl();
        for (int i = 0; i < 256; i++) word_tbl[i] = 16'($urandom);
    endtask

    task automatic run_scan(input logic [15:0] m, input int sup, input int extra_at);
        int s0, d0, e0, c0, v0, b0, cv0, guard, n;
        int exp_idx [0:15];
        s0 = s_n; d0 = done_n; e0 = err_n; c0 = cmd_n; v0 = eoc_viol; b0 = bad_len; cv0 = conv_n;
        sup_abs = (sup > 0) ? cv0 + sup : -1;
        n = 0;
        for (int i = 0; i < 16; i++) if (m[i]) begin exp_idx[n] = i; n++; end
        @(negedge clk); trig = 1'b1; mask = m;
        @(negedge clk); trig = 1'b0;
        chk(busy === 1'b1, "R9", "busy after trigger", int'(busy), 1);
        guard = 0;
        while (done_n == d0 && err_n == e0 && guard < 20000) begin
            @(negedge clk);
            guard++;
            if (guard == extra_at) begin trig = 1'b1; mask = 16'hFFFF; end
            else if (guard == extra_at + 1) trig = 1'b0;
        end
        repeat (80) @(negedge clk);
        if (sup == 0 || sup > n) begin
            chk(done_n - d0 == 1, "R7", "done count", done_n - d0, 1);
            chk(err_n == e0, "R6", "no error", err_n - e0, 0);
            chk(s_n - s0 == n, "R7", "sample count", s_n - s0, n);
            for (int k = 0; k < n && k < s_n - s0; k++) begin
                chk(s_idx[s0+k] == 4'(exp_idx[k]), "R7", "sample index",
                    int'(s_idx[s0+k]), exp_idx[k]);
                chk(s_val[s0+k] == exp_val(word_tbl[exp_cmd(exp_idx[k])]), "R3",
                    "sample value", int'(s_val[s0+k]),
                    int'(exp_val(word_tbl[exp_cmd(exp_idx[k])])));
            end
            chk(cmd_n - c0 == n + 1, "R1", "command count", cmd_n - c0, n + 1);
            for (int k = 0; k < n && c0 + k < cmd_n; k++)
                chk(cmd_log[c0+k] == exp_cmd(exp_idx[k]), "R1", "command byte",
                    int'(cmd_log[c0+k]), int'(exp_cmd(exp_idx[k])));
            if (cmd_n - c0 == n + 1)
                chk(cmd_log[c0+n] == 8'h0C, "R1", "status command", int'(cmd_log[c0+n]), 12);
            chk(eoc_viol == v0, "R5", "transfer before EOC", eoc_viol - v0, 0);
            chk(bad_len == b0, "R2", "transfer length", bad_len - b0, 0);
        end else begin
            chk(err_n - e0 == 1, "R6", "timeout pulse", err_n - e0, 1);
            chk(s_n == s0, "R6", "samples after abort", s_n - s0, 0);
            chk(done_n == d0, "R6", "done after abort", done_n - d0, 0);
            chk(cmd_n - c0 == sup, "R6", "transfers after abort", cmd_n - c0, sup);
            chk(busy === 1'b0, "R6", "busy after abort", int'(busy), 0);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        fill_tbl();
        repeat (4) @(negedge clk);
        // R10 reset state
        chk(cs_n === 1'b1, "R10", "cs_n in reset", int'(cs_n), 1);
        chk(sclk === 1'b0, "R10", "sclk in reset", int'(sclk), 0);
        chk(busy === 1'b0 && smp_valid === 1'b0 && done === 1'b0 && err === 1'b0,
            "R10", "strobes in reset", int'({busy, smp_valid, done, err}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(cs_n === 1'b1 && busy === 1'b0, "R10", "idle after reset", int'({cs_n, busy}), 2);

        // R8 empty mask
        begin
            int c0 = cmd_n;
            @(negedge clk); trig = 1'b1; mask = 16'h0000;
            @(negedge clk); trig = 1'b0;
            chk(done === 1'b1, "R8", "done after empty trigger", int'(done), 1);
            chk(busy === 1'b0, "R8", "busy on empty mask", int'(busy), 0);
            repeat (30) @(negedge clk);
            chk(cmd_n == c0, "R8", "no transfer on empty mask", cmd_n - c0, 0);
        end

        // R4 sign extension corners
        fill_tbl();
        word_tbl[exp_cmd(0)]  = 16'h8007;
        word_tbl[exp_cmd(8)]  = 16'hFFFF;
        word_tbl[exp_cmd(15)] = 16'h7FF8;
        run_scan(16'h8101, 0, -10);
        chk(s_val[s_n-3] == 16'hF000, "R4", "most negative", int'(s_val[s_n-3]), 16'hF000);
        chk(s_val[s_n-2] == 16'hFFFF, "R4", "minus one", int'(s_val[s_n-2]), 16'hFFFF);
        chk(s_val[s_n-1] == 16'h0FFF, "R4", "most positive", int'(s_val[s_n-1]), 16'h0FFF);

        // single channel and full mask
        fill_tbl(); run_scan(16'h0001, 0, -10);
        fill_tbl(); run_scan(16'h8000, 0, -10);
        fill_tbl(); run_scan(16'hFFFF, 0, -10);

        // R9 trigger while busy
        fill_tbl(); run_scan(16'h0005, 0, 40);

        // R6 timeouts: first, middle, last conversion
        fill_tbl(); run_scan(16'h00F0, 1, -10);
        fill_tbl(); run_scan(16'h0F0F, 4, -10);
        fill_tbl(); run_scan(16'h8421, 4, -10);
        fill_tbl(); run_scan(16'h0300, 0, -10);

        // random masks, dense and sparse
        for (int t = 0; t < 30; t++) begin
            logic [15:0] m;
            m = 16'($urandom);
            if (t % 3 == 1) m = m & 16'($urandom) & 16'($urandom);
            if (m == '0) m = 16'h0400;
            fill_tbl();
            run_scan(m, 0, -10);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual 0 expected 1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule